// File: doc/BRIEF.md
# Weighted Time-Slice LED Brightness Controller

This block turns 8-bit brightness codes stored as bit planes into lit time on a chain of cascaded serial-in, latched-output LED drivers. Each refresh splits into one display slice per bit weight. Slice p lasts TICK·2^p clock cycles. Every pixel on the chain shares the same slice timing, so one sequencer converts all pixels at once and no pixel needs its own counter.

For each plane the controller reads one bit per pixel through a bit-plane read port and shifts it down the chain. It then fires a single latch pulse that moves the whole chain into the driver outputs, and enables the outputs for that plane's slice. The next plane is shifted while the current one is on display. A short slice that ends before its successor has been shifted is followed by blanking until the shift is complete. A start-of-frame pulse restarts the sequence at plane 0, and a done flag reports that the top plane has been shown.

Top module: `wslice_led_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released until the first frame_start, sdata, sclk, latch, oe and frame_done are all 0.
- R2: A plane is shifted as CHAIN bits, highest pixel index first and index 0 last. Each bit occupies two cycles: sclk is 0 in the first and 1 in the second. Throughout both cycles sdata equals rd_bit for the address rd_plane/rd_pix of that bit (1 = LED on).
- R3: latch is a one-cycle pulse with oe and sclk both 0. It is issued only once every bit of the plane about to be shown has been shifted in.
- R4: oe goes high in the cycle that follows a latch pulse and stays high for exactly TICK·2^p cycles for plane p. A complete frame therefore holds oe high for TICK·(2^BITS−1) cycles and carries BITS latch pulses.
- R5: Shifting of plane p+1 begins in the first cycle that plane p is displayed.
- R6: If the next plane is still being shifted when a slice ends, oe stays 0 until the last bit has been clocked. latch then follows in the next cycle. If shifting is already complete, latch comes in the cycle right after the slice ends.
- R7: Planes are shown in the order 0, 1, …, BITS−1. After the last slice, oe, latch, sclk and sdata stay 0 and frame_done stays 1 until the next frame_start.
- R8: frame_start sampled high at any time abandons the current frame and clears frame_done. Shifting of plane 0 starts in the next cycle, and the first latch follows 2·CHAIN cycles later.
- R9: A pixel with code 0 gives sdata 0 in every plane, so the LED is dark for the whole frame. A pixel with code 255 gives sdata 1 in all eight planes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that starts a refresh at plane 0 |
| rd_plane | output | $clog2(BITS) | Bit-plane index being read |
| rd_pix | output | max(1,$clog2(CHAIN)) | Pixel index being read |
| rd_bit | input | 1 | Stored bit for rd_plane/rd_pix, returned in the same cycle |
| sdata | output | 1 | Serial data to the driver chain |
| sclk | output | 1 | Shift clock; the chain samples sdata on its rising edge |
| latch | output | 1 | Shared strobe that moves the chain into the driver outputs |
| oe | output | 1 | Output enable for the driver stage |
| frame_done | output | 1 | High once the top plane has been displayed |

## Verification
The bench builds the block with CHAIN=4, TICK=1 and BITS=8, so a plane takes eight cycles to shift. With those values the slices of planes 0 to 2 are shorter than a shift and force blanking. Plane 3 ends in exactly the cycle the shift finishes, and planes 4 to 7 leave the shifter idle for part of their slice. One short run therefore reaches every boundary case of R6. The bench also covers all-dark, all-lit and mixed planes, and a restart in the middle of a frame.

// File: rtl/wslice_pkg.sv
package wslice_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SHOW = 2'd2
   } seq_state_t;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/wslice_shifter.sv
module wslice_shifter #(
   parameter int CHAIN = 4,
   parameter int PW    = 3,
   parameter int XW    = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW-1:0] plane_in,
   output logic          busy,
   output logic          sclk,
   output logic [PW-1:0] rd_plane,
   output logic [XW-1:0] rd_pix
);
   logic          run_q;
   logic          ph_q;
   logic [XW-1:0] pix_q;
   logic [PW-1:0] plane_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         ph_q    <= 1'b0;
         pix_q   <= '0;
         plane_q <= '0;
      end else if (start) begin
         run_q   <= 1'b1;
         ph_q    <= 1'b0;
         pix_q   <= XW'(CHAIN - 1);
         plane_q <= plane_in;
      end else if (run_q) begin
         if (!ph_q) begin
            ph_q <= 1'b1;
         end else begin
            ph_q <= 1'b0;
            if (pix_q == '0) run_q <= 1'b0;
            else             pix_q <= pix_q - XW'(1);
         end
      end
   end

   assign busy     = run_q;
   assign sclk     = run_q & ph_q;
   assign rd_plane = plane_q;
   assign rd_pix   = pix_q;
endmodule

// File: rtl/wslice_timer.sv
module wslice_timer #(
   parameter int BITS = 8,
   parameter int TICK = 1,
   parameter int PW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] plane,
   output logic          last
);
   localparam int MAXSPAN = TICK * (2 ** (BITS - 1));
   localparam int CW      = $clog2(MAXSPAN + 1);
   localparam bit POW2    = ((TICK & (TICK - 1)) == 0);

   logic [CW-1:0] span;
   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_shift_span
         localparam int TSH = $clog2(TICK);
         assign span = CW'(1) << (int'(plane) + TSH);
      end else begin : g_mult_span
         assign span = CW'(TICK) * (CW'(1) << plane);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= span - CW'(1);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/wslice_sequencer.sv
module wslice_sequencer
   import wslice_pkg::*;
#(
   parameter int BITS = 8,
   parameter int PW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          sh_busy,
   input  logic          t_last,
   output logic          sh_start,
   output logic [PW-1:0] sh_plane,
   output logic          t_load,
   output logic [PW-1:0] t_plane,
   output logic          latch,
   output logic          oe,
   output logic          done
);
   localparam logic [PW-1:0] LAST = PW'(BITS - 1);

   seq_state_t    st_q;
   logic [PW-1:0] disp_q;
   logic          done_q;

   assign latch    = (st_q == ST_WAIT) & ~sh_busy & ~sof;
   assign sh_start = sof | (latch & (disp_q != LAST));
   assign sh_plane = sof ? '0 : disp_q + PW'(1);
   assign t_load   = latch;
   assign t_plane  = disp_q;
   assign oe       = (st_q == ST_SHOW);
   assign done     = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         disp_q <= '0;
         done_q <= 1'b0;
      end else if (sof) begin
         st_q   <= ST_WAIT;
         disp_q <= '0;
         done_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_WAIT: if (latch) st_q <= ST_SHOW;
            ST_SHOW: if (t_last) begin
               if (disp_q == LAST) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  disp_q <= disp_q + PW'(1);
                  st_q   <= ST_WAIT;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wslice_led_ctrl.sv
module wslice_led_ctrl
   import wslice_pkg::*;
#(
   parameter int BITS  = 8,
   parameter int CHAIN = 4,
   parameter int TICK  = 1,
   localparam int PW   = idx_w(BITS),
   localparam int XW   = idx_w(CHAIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_start,
   output logic [PW-1:0] rd_plane,
   output logic [XW-1:0] rd_pix,
   input  logic          rd_bit,
   output logic          sdata,
   output logic          sclk,
   output logic          latch,
   output logic          oe,
   output logic          frame_done
);
   generate
      if (BITS < 2 || BITS > 16) begin : g_bad_bits
         $error("BITS must lie in 2..16");
      end
      if (CHAIN < 1) begin : g_bad_chain
         $error("CHAIN must be at least 1");
      end
      if (TICK < 1) begin : g_bad_tick
         $error("TICK must be at least 1");
      end
   endgenerate

   logic          sh_busy;
   logic          sh_start;
   logic [PW-1:0] sh_plane;
   logic          t_load;
   logic [PW-1:0] t_plane;
   logic          t_last;

   wslice_sequencer #(.BITS(BITS), .PW(PW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sof      (frame_start),
      .sh_busy  (sh_busy),
      .t_last   (t_last),
      .sh_start (sh_start),
      .sh_plane (sh_plane),
      .t_load   (t_load),
      .t_plane  (t_plane),
      .latch    (latch),
      .oe       (oe),
      .done     (frame_done)
   );

   wslice_shifter #(.CHAIN(CHAIN), .PW(PW), .XW(XW)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (sh_start),
      .plane_in (sh_plane),
      .busy     (sh_busy),
      .sclk     (sclk),
      .rd_plane (rd_plane),
      .rd_pix   (rd_pix)
   );

   wslice_timer #(.BITS(BITS), .TICK(TICK), .PW(PW)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (t_load),
      .plane (t_plane),
      .last  (t_last)
   );

   assign sdata = sh_busy & rd_bit;
endmodule

// File: rtl/wslice_led_ctrl_chk.sv
module wslice_led_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_start,
   input logic sdata,
   input logic sclk,
   input logic latch,
   input logic oe,
   input logic frame_done
);
   p_sclk_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |=> !sclk);
   p_sdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));
   p_latch_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch |-> (!oe && !sclk));
   p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> !latch);
   p_oe_after_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(latch));
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (!oe && !latch && !sclk && !sdata));
   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (!oe && !frame_done));
endmodule

bind wslice_led_ctrl wslice_led_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .sdata       (sdata),
   .sclk        (sclk),
   .latch       (latch),
   .oe          (oe),
   .frame_done  (frame_done)
);

// File: tb/wslice_led_ctrl_tb.sv
module wslice_led_ctrl_tb;
   localparam int BITS  = 8;
   localparam int CHAIN = 4;
   localparam int TICK  = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic [2:0] rd_plane;
   logic [1:0] rd_pix;
   logic       rd_bit;
   logic       sdata, sclk, latch, oe, frame_done;

   logic mem [0:BITS-1][0:CHAIN-1];

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   logic [3:0] q[$];
   bit fin = 1'b0;
   int n_oe = 0;
   int n_lat = 0;

   always #10 clk = ~clk;

   assign rd_bit = mem[rd_plane][rd_pix];

   wslice_led_ctrl #(.BITS(BITS), .CHAIN(CHAIN), .TICK(TICK)) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .rd_plane(rd_plane), .rd_pix(rd_pix), .rd_bit(rd_bit),
      .sdata(sdata), .sclk(sclk), .latch(latch), .oe(oe),
      .frame_done(frame_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests = n_tests + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic push_shift_step(input int p, input int t, input bit show);
      int k = CHAIN - 1 - t / 2;
      q.push_back({1'(t % 2), mem[p][k], 1'b0, show});
   endtask

   task automatic build_frame();
      q.delete();
      fin = 1'b0;
      n_oe = 0;
      n_lat = 0;
      for (int t = 0; t < 2 * CHAIN; t++) push_shift_step(0, t, 1'b0);
      q.push_back(4'b0010);
      for (int p = 0; p < BITS; p++) begin
         int w = TICK << p;
         int s = (p < BITS - 1) ? 2 * CHAIN : 0;
         int len = (w > s) ? w : s;
         for (int t = 0; t < len; t++) begin
            if (t < s) push_shift_step(p + 1, t, t < w);
            else       q.push_back({3'b000, 1'(t < w)});
         end
         if (p < BITS - 1) q.push_back(4'b0010);
      end
   endtask

   task automatic check_cycle();
      logic [3:0] e;
      logic ed;
      if (q.size() > 0) begin
         e = q.pop_front();
         ed = 1'b0;
         if (q.size() == 0) fin = 1'b1;
      end else begin
         e = 4'b0000;
         ed = fin;
      end
      chk(sclk == e[3], "R2 R5 sclk", int'(sclk), int'(e[3]));
      chk(sdata == e[2], "R2 R5 R9 sdata", int'(sdata), int'(e[2]));
      chk(latch == e[1], "R3 R6 latch", int'(latch), int'(e[1]));
      chk(oe == e[0], "R4 R6 oe", int'(oe), int'(e[0]));
      chk(frame_done == ed, "R7 frame_done", int'(frame_done), int'(ed));
      n_oe  = n_oe + int'(oe);
      n_lat = n_lat + int'(latch);
   endtask

   task automatic tick(input bit s);
      @(negedge clk);
      check_cycle();
      frame_start = s;
      if (s) build_frame();
   endtask

   task automatic run_frame(input string tag);
      tick(1'b1);
      while (q.size() > 0) tick(1'b0);
      chk(n_oe == TICK * ((1 << BITS) - 1), {"R4 lit cycles per frame ", tag}, n_oe, TICK * ((1 << BITS) - 1));
      chk(n_lat == BITS, {"R3 latch count per frame ", tag}, n_lat, BITS);
      for (int i = 0; i < 4; i++) tick(1'b0);
   endtask

   initial begin
      for (int p = 0; p < BITS; p++)
         for (int k = 0; k < CHAIN; k++) mem[p][k] = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk({sdata, sclk, latch, oe, frame_done} == 5'b0, "R1 reset outputs",
             int'({sdata, sclk, latch, oe, frame_done}), 0);
      end
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) tick(1'b0);

      run_frame("R9 all dark");

      for (int p = 0; p < BITS; p++)
         for (int k = 0; k < CHAIN; k++) mem[p][k] = 1'b1;
      run_frame("R9 all lit");

      for (int p = 0; p < BITS; p++)
         for (int k = 0; k < CHAIN; k++) mem[p][k] = 1'(((p * 5 + k * 3) ^ k) >> 1);
      run_frame("R7 mixed planes");

      for (int p = 0; p < BITS; p++)
         for (int k = 0; k < CHAIN; k++) mem[p][k] = 1'(p + k);
      tick(1'b1);
      for (int i = 0; i < 57; i++) tick(1'b0);
      run_frame("R8 restart mid frame");
      tick(1'b1);
      for (int i = 0; i < 3; i++) tick(1'b0);
      run_frame("R8 restart during shift");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule